// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Front-End

This block puts a synchronous, pipelined control layer in front of an on-chip memory of 2^AW words. Each word is 18 bits wide and split into two 9-bit byte lanes. Two active-low address strobes can open an access. The processor strobe is gated by the master enable; the controller strobe is not. A master enable and two secondary enables, one active high and one active low, decide on each strobe edge whether the block is selected or deselected. Once an address is loaded, an advance input walks the two low address bits through a four-beat burst. The order is either XOR-interleaved or linear modulo 4, chosen by a static order pin. The upper address bits never move during a burst.

Write enables are decoded per lane. A global write enable writes the whole word. Otherwise a lane is written when both the byte-write enable and that lane's enable are low. Read data is registered, so the word for an address registered on one rising edge drives the outputs after the following rising edge. The bidirectional data pins are split into `d_in`, `d_out` and a drive enable `d_oe`. The drive enable is high only while the asynchronous output enable is low and the pipeline holds read data.

Top module: `burst_sram_core`

## Requirements
- R1: A processor-strobe edge (strobe low, master enable low, both secondary enables active) loads the address and is always a read; the write enables and `d_in` on that edge leave the memory unchanged.
- R2: A controller-strobe edge counts only while the processor strobe is high. Its write enables are sampled on that same edge. With the master enable high it is a deselect, so `d_oe` is 0 two edges later.
- R3: A processor-strobe low while the master enable is high starts nothing and does not advance the burst: the current address is held.
- R4: A strobe edge with any enable inactive is a deselect. The data from the previous read still drives after the next edge, and `d_oe` is 0 after the edge after that.
- R5: After a load, the address steps only on edges where `adv_n` is low and both strobes are high. `adv_n` is ignored on the load edge, and with `adv_n` high the address is held.
- R6: With `order_il` = 1, beat k (k = 0..3) accesses low bits `start[1:0] XOR k`.
- R7: With `order_il` = 0, beat k accesses low bits `(start[1:0] + k) mod 4`.
- R8: Address bits above bit 1 never change during a burst.
- R9: With `wr_all_n` low on a write-qualified edge, all 18 bits of the addressed word take `d_in`.
- R10: With `wr_all_n` high and `wr_byte_n` low, lane 0 (bits 8:0) is written when `lane_wr_n[0]` = 0 and lane 1 (bits 17:9) when `lane_wr_n[1]` = 0. If no lane is enabled, the edge is a read.
- R11: Data for the address registered on edge k is on `d_out` with `d_oe` = 1 after edge k+1.
- R12: `d_oe` is 0 whenever `oe_n` is high, and after any edge that samples an active write.
- R13: Synchronous active-low reset deselects the block and leaves `d_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW (6) | External word address |
| strb_cpu_n | input | 1 | Processor address strobe, gated by the master enable |
| strb_ctl_n | input | 1 | Controller address strobe |
| en_main_n | input | 1 | Master enable, active low |
| en_hi | input | 1 | Secondary enable, active high |
| en_lo_n | input | 1 | Secondary enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write enable, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | 2 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| d_in | input | 18 | Write data |
| d_out | output | 18 | Read data |
| d_oe | output | 1 | Drive enable for the data pins |

## Verification
A wrong beat counter or base offset shows up as the wrong word on `d_out` one edge after the faulty step, so each beat is compared to a reference memory on the cycle it arrives. A select flag stuck active shows as `d_oe` still high two edges after a deselect. A write decode that leaks through a processor-strobe edge or into a masked lane corrupts a word silently, and is seen only when that word is next read. For that reason every write burst is followed by a read burst over the same four addresses.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {CY_IDLE, CY_READ, CY_WRITE} cyc_kind_t;
endpackage

// File: rtl/bsr_burst_addr.sv
// Address register with a four-beat burst sequencer on the two low bits.
module bsr_burst_addr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          interleave,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] sel_addr,
  output logic [AW-1:0] cur_addr
);
  logic [1:0] base_lo, cnt, cnt_nx, lo_nx;

  always_comb begin
    cnt_nx = cnt + 2'd1;
    lo_nx  = interleave ? (base_lo ^ cnt_nx) : (base_lo + cnt_nx);
    if (load)      sel_addr = ext_addr;
    else if (step) sel_addr = {cur_addr[AW-1:2], lo_nx};
    else           sel_addr = cur_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      base_lo  <= '0;
      cnt      <= '0;
    end else begin
      cur_addr <= sel_addr;
      if (load) begin
        base_lo <= ext_addr[1:0];
        cnt     <= '0;
      end else if (step) begin
        cnt <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/bsr_wr_decode.sv
// Global / per-lane write enable decode.
module bsr_wr_decode #(
  parameter int LANES = 2
) (
  input  logic             allow,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] lane_we,
  output logic             wr_any
);
  always_comb begin
    if (!allow)          lane_we = '0;
    else if (!wr_all_n)  lane_we = '1;
    else if (!wr_byte_n) lane_we = ~lane_n;
    else                 lane_we = '0;
    wr_any = |lane_we;
  end
endmodule

// File: rtl/bsr_array.sv
// Lane-split storage array, synchronous write, combinational read.
module bsr_array #(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
  end
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core #(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    en_main_n,
  input  logic                    en_hi,
  input  logic                    en_lo_n,
  input  logic                    adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    oe_n,
  input  logic                    order_il,
  input  logic [LANES*LANE_W-1:0] d_in,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic                    d_oe
);
  import bsr_pkg::*;
  localparam int DW = LANES * LANE_W;

  logic start_cpu, start_ctl, start_any, en_ok;
  logic load, desel, cont, step, allow_wr, wr_any, active, out_valid;
  logic [LANES-1:0] lane_we;
  logic [AW-1:0] sel_addr, cur_addr;
  logic [DW-1:0] rdata, dq;
  cyc_kind_t kind;

  // Strobe qualification: master enable gates only the processor strobe.
  always_comb begin
    start_cpu = !strb_cpu_n && !en_main_n;
    start_ctl = !strb_ctl_n && strb_cpu_n;
    start_any = start_cpu || start_ctl;
    en_ok     = !en_main_n && en_hi && !en_lo_n;
    load      = start_any && en_ok;
    desel     = start_any && !en_ok;
    cont      = !start_any && active;
    step      = cont && !adv_n && strb_cpu_n && strb_ctl_n;
    allow_wr  = (load && !start_cpu) || cont;
  end

  bsr_burst_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .interleave(order_il), .ext_addr(addr),
    .sel_addr(sel_addr), .cur_addr(cur_addr)
  );

  bsr_wr_decode #(.LANES(LANES)) u_wdec (
    .allow(allow_wr), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_n(lane_wr_n), .lane_we(lane_we), .wr_any(wr_any)
  );

  bsr_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .we(lane_we), .waddr(sel_addr), .wdata(d_in),
    .raddr(cur_addr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      kind      <= CY_IDLE;
      out_valid <= 1'b0;
      dq        <= '0;
    end else begin
      if (load)       active <= 1'b1;
      else if (desel) active <= 1'b0;
      if (load || cont) kind <= wr_any ? CY_WRITE : CY_READ;
      else              kind <= CY_IDLE;
      out_valid <= (kind == CY_READ) && !wr_any;
      if (kind == CY_READ) dq <= rdata;
    end
  end

  assign d_out = dq;
  assign d_oe  = out_valid && !oe_n;
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          desel,
  input logic          wr_any,
  input logic          step,
  input logic          cont,
  input logic          d_oe,
  input logic [AW-1:0] cur_addr
);
  AST_DESEL_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> ##1 !d_oe); // R4
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !d_oe); // R12
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !step) |=> $stable(cur_addr)); // R5
  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cur_addr != $past(cur_addr))); // R6
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(cur_addr[AW-1:2])); // R8
endmodule

bind burst_sram_core bsr_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .desel(desel), .wr_any(wr_any),
  .step(step), .cont(cont), .d_oe(d_oe), .cur_addr(cur_addr)
);

// File: tb/burst_sram_core_bench.sv
`timescale 1ns/100ps
module burst_sram_core_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, strb_cpu_n, strb_ctl_n, en_main_n, en_hi, en_lo_n, adv_n;
  logic wr_all_n, wr_byte_n, oe_n, order_il, d_oe;
  logic [1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [17:0] d_in, d_out;
  logic [17:0] ref_mem [DEPTH];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  burst_sram_core u_burst_sram_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .en_main_n(en_main_n), .en_hi(en_hi),
    .en_lo_n(en_lo_n), .adv_n(adv_n), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
    .order_il(order_il), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
  );

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] s, int k, logic il);
    logic [1:0] lo;
    lo = il ? (s[1:0] ^ 2'(k)) : (s[1:0] + 2'(k));
    return {s[AW-1:2], lo};
  endfunction

  function automatic logic [17:0] merge(logic [17:0] old, logic [17:0] nw,
                                        logic all_n, logic byte_n, logic [1:0] ln);
    logic [17:0] r;
    r = old;
    if (!all_n) r = nw;
    else if (!byte_n) begin
      if (!ln[0]) r[8:0]  = nw[8:0];
      if (!ln[1]) r[17:9] = nw[17:9];
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [17:0] act, logic [17:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1; en_main_n = 0; en_hi = 1;
    en_lo_n = 0; wr_all_n = 1; wr_byte_n = 1; lane_wr_n = 2'b11; oe_n = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic deselect_in();
    idle_in(); strb_ctl_n = 0; en_hi = 0;
  endtask

  // Four-beat write burst opened by the controller strobe.
  task automatic wr_burst(logic [AW-1:0] s, logic il, bit full);
    logic an, bn, wr;
    logic [1:0] ln;
    logic [17:0] dv;
    order_il = il;
    for (int k = 0; k < 4; k++) begin
      idle_in();
      if (k == 0) begin strb_ctl_n = 0; addr = s; end
      else adv_n = 0;
      an = full ? 1'b0 : (($urandom % 4) == 0 ? 1'b0 : 1'b1);
      bn = full ? 1'b1 : 1'($urandom % 2);
      ln = 2'($urandom);
      dv = 18'($urandom);
      wr_all_n = an; wr_byte_n = bn; lane_wr_n = ln; d_in = dv;
      wr = !an || (!bn && ln != 2'b11);
      ref_mem[beat_addr(s, k, il)] = merge(ref_mem[beat_addr(s, k, il)], dv, an, bn, ln);
      tick();
      if (wr) chk(d_oe == 1'b0, "R12 write edge leaves pins floating", 18'(d_oe), 18'd0);
    end
    deselect_in(); tick();
    idle_in(); tick();
  endtask

  // Four-beat read burst; last beat edge carries a deselect.
  task automatic rd_burst(logic [AW-1:0] s, logic il, bit use_cpu, bit junk, string tag);
    order_il = il;
    idle_in();
    addr = s;
    if (use_cpu) begin
      strb_cpu_n = 0;
      strb_ctl_n = 1'($urandom);
      if (junk) begin wr_all_n = 0; d_in = 18'($urandom); end
    end else strb_ctl_n = 0;
    tick();
    idle_in(); adv_n = 0;
    for (int k = 0; k < 4; k++) begin
      if (k == 3) deselect_in();
      tick();
      chk(d_out == ref_mem[beat_addr(s, k, il)], tag, d_out, ref_mem[beat_addr(s, k, il)]);
      if (k == 0) chk(d_oe == 1'b1, "R11 data one edge after address", 18'(d_oe), 18'd1);
    end
    idle_in(); tick();
    chk(d_oe == 1'b0, "R4 float after deselect", 18'(d_oe), 18'd0);
  endtask

  // Hold test: mode 0 uses adv_n high (R5), mode 1 a gated processor strobe (R3).
  task automatic hold_test(logic [AW-1:0] s, int mode);
    string tg;
    tg = (mode == 0) ? "R5 advance high holds" : "R3 gated processor strobe holds";
    order_il = 1;
    idle_in(); strb_ctl_n = 0; addr = s; tick();
    idle_in();
    if (mode == 0) adv_n = 1;
    else begin adv_n = 0; strb_cpu_n = 0; en_main_n = 1; end
    tick();
    chk(d_out == ref_mem[s], tg, d_out, ref_mem[s]);
    idle_in(); adv_n = 0; tick();
    chk(d_out == ref_mem[s], tg, d_out, ref_mem[s]);
    tick();
    chk(d_out == ref_mem[beat_addr(s, 1, 1)], tg, d_out, ref_mem[beat_addr(s, 1, 1)]);
    deselect_in(); tick(); idle_in(); tick();
  endtask

  initial begin
    logic [AW-1:0] s;
    idle_in(); order_il = 1; addr = '0; d_in = '0; rst_n = 0;
    repeat (3) tick();
    chk(d_oe == 1'b0, "R13 reset floats pins", 18'(d_oe), 18'd0);
    rst_n = 1; tick();
    chk(d_oe == 1'b0, "R13 deselected after reset", 18'(d_oe), 18'd0);

    // Fill all words with full-word writes (R9), alternating order.
    for (int b = 0; b < DEPTH / 4; b++)
      wr_burst(AW'(b * 4 + (b % 4)), 1'(b % 2), 1'b1);

    // Every start offset in both orders.
    for (int o = 0; o < 4; o++) begin
      s = {AW-2'($urandom), 2'(o)};
      rd_burst(s, 1'b1, 1'b0, 1'b0, "R6/R8 interleaved beat");
      rd_burst(s, 1'b0, 1'b0, 1'b0, "R7/R8 linear beat");
    end

    // R1: processor strobe with write enables asserted stays a read.
    rd_burst(AW'(9), 1'b0, 1'b1, 1'b1, "R1 processor start ignores writes");

    // Random mixed-lane write bursts, read back in random order.
    for (int i = 0; i < 40; i++) begin
      s = AW'($urandom);
      wr_burst(s, 1'($urandom), 1'b0);
      rd_burst(s, 1'($urandom), 1'($urandom), 1'b0, "R9/R10 lane merge readback");
    end

    hold_test(AW'(21), 0);
    hold_test(AW'(42), 1);

    // R10: byte-write enable with no lane selected is a read.
    idle_in(); strb_ctl_n = 0; addr = AW'(13); wr_byte_n = 0; lane_wr_n = 2'b11;
    d_in = ~ref_mem[13]; tick();
    deselect_in(); tick();
    chk(d_oe == 1'b1, "R10 no lane means read", 18'(d_oe), 18'd1);
    chk(d_out == ref_mem[13], "R10 no lane leaves word", d_out, ref_mem[13]);
    idle_in(); tick();

    // R2: controller strobe with master enable high deselects; R12 oe_n gate.
    idle_in(); strb_ctl_n = 0; addr = AW'(30); tick();
    idle_in(); adv_n = 0; tick();
    chk(d_out == ref_mem[30], "R2 controller start read", d_out, ref_mem[30]);
    oe_n = 1; #0.5;
    chk(d_oe == 1'b0, "R12 oe_n high floats pins", 18'(d_oe), 18'd0);
    oe_n = 0; #0.5;
    chk(d_oe == 1'b1, "R12 oe_n low drives", 18'(d_oe), 18'd1);
    idle_in(); strb_ctl_n = 0; en_main_n = 1; tick();
    chk(d_oe == 1'b1, "R2 read data still out", 18'(d_oe), 18'd1);
    idle_in(); tick();
    chk(d_oe == 1'b0, "R2 master high deselects controller start", 18'(d_oe), 18'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule